// File: doc/BRIEF.md
# Paper Tape Reader Controller

This block connects an 8-bit tape frame source to the I/O bus of an 18-bit processor. The processor talks to it through a strobed command word whose individual bits ask for three things. One bit tests the reader's completion flag and asks the bus to skip. One bit returns the assembled word and drops the completion flag. One bit starts a new read, and a companion bit chooses the read format.

Frames arrive on a byte stream with a valid/ready handshake. A character read takes a single frame and stores it in one of three ways: as received, with bit 7 rewritten to make even parity over the eight bits, or with bit 7 forced high. A binary read packs the low six bits of three frames into one 18-bit word, filling it from the most significant slice downward. It passes over any frame that lacks the bit-7 punch. If the source reports that no tape is present while a read is waiting, the read ends with both the completion flag and the error flag set.

Top module: `tape_reader_ctrl`

## Requirements
- R1: While `io_strobe` is high with command bit 0 set, `io_skip` is high in that same cycle exactly when `done_flag` is set; `io_skip` is low in all other cycles.
- R2: While `io_strobe` is high with command bit 1 set, `io_data_out` equals `io_data_in` OR the 18-bit read word in that same cycle, and `done_flag` is clear after the clock edge. Without that bit, `io_data_out` equals `io_data_in`.
- R3: A strobe with command bit 2 set clears `done_flag`, `err_flag` and the read word at the next edge and starts a read. Command bit 5 selects binary format when set and character format when clear.
- R4: `frm_ready` is high only while a read is in progress, `done_flag` is clear, `tape_absent` is low and no start command is being strobed.
- R5: In binary format, a frame with bit 7 clear is consumed but changes neither the word nor the flags, and the read keeps waiting.
- R6: In binary format, the low six bits of the first, second and third frames that have bit 7 set land in word bits 17:12, 11:6 and 5:0 respectively. The read completes on the third such frame.
- R7: In character format with `par_mode` 0 or 3, the word holds the frame unchanged in bits 7:0, with zeros above, and the read completes on that frame.
- R8: In character format with `par_mode` 1, word bits 6:0 are the frame's bits 6:0, and bit 7 is set exactly when those seven bits hold an odd number of ones.
- R9: In character format with `par_mode` 2, the word holds the frame with bit 7 forced to 1.
- R10: When `tape_absent` is high while a read is in progress, `done_flag` and `err_flag` are both set at the next edge and the read ends. `err_flag` stays set until a start command or reset, even after a read command clears `done_flag`.
- R11: A synchronous high `rst` clears the read word, both flags and any read in progress, so `frm_ready` is low afterwards.
- R12: `done_flag` rises at the clock edge that accepts the completing frame and is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strobe | input | 1 | Command word valid for this cycle |
| io_pulse | input | 6 | Command bits: 0 skip test, 1 read word, 2 start read, 5 binary format |
| io_data_in | input | 18 | Data bus value arriving from other devices |
| io_data_out | output | 18 | Data bus value with the read word merged on a read command |
| io_skip | output | 1 | Skip request to the processor |
| par_mode | input | 2 | Character parity policy: 0 or 3 as received, 1 even, 2 forced high |
| frm_valid | input | 1 | A tape frame is offered |
| frm_data | input | 8 | Offered tape frame |
| frm_ready | output | 1 | Controller takes the offered frame at this edge |
| tape_absent | input | 1 | Source is at end of tape or not connected |
| done_flag | output | 1 | Read complete |
| err_flag | output | 1 | Read ended without tape |

## Verification
The skip answer and the merged bus data are combinational, so they are due in the cycle the command is strobed. The bench samples them one time step after driving the command at the falling edge, and a monitor compares each read against a queue of expected words. Flag effects of a command, a consumed frame or a missing tape appear one edge later. Every such check is therefore taken at the falling edge that follows the accepting rising edge, with `done_flag` also confirmed low before the completing frame.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int WORD_W  = 18;
    localparam int FRAME_W = 8;
    localparam int SLICE_W = 6;
    localparam int PULSE_W = 6;

    // Command bit masks on the strobed command word
    localparam logic [PULSE_W-1:0] CMD_SKIP_M   = 6'b000001;
    localparam logic [PULSE_W-1:0] CMD_READ_M   = 6'b000010;
    localparam logic [PULSE_W-1:0] CMD_START_M  = 6'b000100;
    localparam logic [PULSE_W-1:0] CMD_BINARY_M = 6'b100000;

    typedef enum logic [1:0] {
        PAR_PLAIN = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_FORCE = 2'd2,
        PAR_RAW   = 2'd3
    } par_mode_e;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_CHAR   = 2'd1,
        RD_BINARY = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic skip;
        logic read;
        logic start;
        logic binary;
    } iot_cmd_t;

    typedef struct packed {
        logic ok;
        logic err;
    } rd_end_t;

    // Character-format frame conversion under a parity policy
    function automatic logic [FRAME_W-1:0] char_frame(par_mode_e mode,
                                                      logic [FRAME_W-1:0] f);
        logic [FRAME_W-1:0] r;
        case (mode)
            PAR_EVEN:  r = {^f[FRAME_W-2:0], f[FRAME_W-2:0]};
            PAR_FORCE: r = {1'b1, f[FRAME_W-2:0]};
            default:   r = f;
        endcase
        return r;
    endfunction

    function automatic logic has_punch(logic [FRAME_W-1:0] f);
        return f[FRAME_W-1];
    endfunction

endpackage

// File: rtl/trc_iot_decode.sv
module trc_iot_decode
    import trc_pkg::*;
#(
    parameter int PW = PULSE_W
) (
    input  logic          strobe,
    input  logic [PW-1:0] pulse,
    output iot_cmd_t      cmd
);

    always_comb begin
        cmd.skip   = strobe && (|(pulse & PW'(CMD_SKIP_M)));
        cmd.read   = strobe && (|(pulse & PW'(CMD_READ_M)));
        cmd.start  = strobe && (|(pulse & PW'(CMD_START_M)));
        cmd.binary = strobe && (|(pulse & PW'(CMD_BINARY_M)));
    end

endmodule

// File: rtl/trc_frame_pack.sv
module trc_frame_pack
    import trc_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int FW = FRAME_W,
    parameter int SW = SLICE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          binary,
    input  par_mode_e     mode,
    input  logic          take,
    input  logic [FW-1:0] frame,
    input  logic          no_tape,
    output logic [WW-1:0] word,
    output logic          busy,
    output rd_end_t       fin
);

    localparam int SLICES = WW / SW;
    localparam int SH_W   = $clog2(WW + 1);
    localparam logic [SH_W-1:0] SH_FULL = SH_W'(WW);
    localparam logic [SH_W-1:0] SH_STEP = SH_W'(SW);

    rd_state_e       state;
    logic [SH_W-1:0] shift;
    logic [WW-1:0]   merged;
    logic [SLICES-1:0] lane_hit;
    logic            punched;
    logic            last_slice;

    assign punched    = has_punch(frame);
    assign last_slice = (shift == SH_STEP);

    // Each lane takes the frame's low slice when the shift count points at it
    for (genvar g = 0; g < SLICES; g++) begin : g_lane
        assign lane_hit[g] = (shift == SH_W'((g + 1) * SW));
        assign merged[g*SW +: SW] = word[g*SW +: SW] |
                                    (lane_hit[g] ? frame[SW-1:0] : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
            shift <= '0;
            word  <= '0;
        end else if (start) begin
            word  <= '0;
            shift <= binary ? SH_FULL : '0;
            state <= binary ? RD_BINARY : RD_CHAR;
        end else if (state != RD_IDLE && no_tape) begin
            state <= RD_IDLE;
        end else if (take) begin
            unique case (state)
                RD_CHAR: begin
                    word  <= WW'(char_frame(mode, frame));
                    state <= RD_IDLE;
                end
                RD_BINARY: begin
                    if (punched) begin
                        word  <= merged;
                        shift <= shift - SH_STEP;
                        if (last_slice) state <= RD_IDLE;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign busy = (state != RD_IDLE);

    always_comb begin
        fin.err = busy && no_tape && !start;
        fin.ok  = take && !start && !no_tape &&
                  ((state == RD_CHAR) ||
                   (state == RD_BINARY && punched && last_slice));
    end

endmodule

// File: rtl/trc_status.sv
module trc_status
    import trc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    read_clr,
    input  rd_end_t fin,
    output logic    done,
    output logic    err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (fin.ok || fin.err)
                done <= 1'b1;
            else if (start || read_clr)
                done <= 1'b0;

            if (fin.err)
                err <= 1'b1;
            else if (start)
                err <= 1'b0;
        end
    end

endmodule

// File: rtl/tape_reader_ctrl.sv
module tape_reader_ctrl
    import trc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                io_strobe,
    input  logic [PULSE_W-1:0]  io_pulse,
    input  logic [WORD_W-1:0]   io_data_in,
    output logic [WORD_W-1:0]   io_data_out,
    output logic                io_skip,
    input  logic [1:0]          par_mode,
    input  logic                frm_valid,
    input  logic [FRAME_W-1:0]  frm_data,
    output logic                frm_ready,
    input  logic                tape_absent,
    output logic                done_flag,
    output logic                err_flag
);

    iot_cmd_t          cmd;
    rd_end_t           fin;
    logic [WORD_W-1:0] word;
    logic              busy;
    logic              take;

    trc_iot_decode #(.PW(PULSE_W)) u_decode (
        .strobe (io_strobe),
        .pulse  (io_pulse),
        .cmd    (cmd)
    );

    assign frm_ready = busy && !done_flag && !tape_absent && !cmd.start;
    assign take      = frm_valid && frm_ready;

    trc_frame_pack #(.WW(WORD_W), .FW(FRAME_W), .SW(SLICE_W)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .start   (cmd.start),
        .binary  (cmd.binary),
        .mode    (par_mode_e'(par_mode)),
        .take    (take),
        .frame   (frm_data),
        .no_tape (tape_absent),
        .word    (word),
        .busy    (busy),
        .fin     (fin)
    );

    trc_status u_status (
        .clk      (clk),
        .rst      (rst),
        .start    (cmd.start),
        .read_clr (cmd.read),
        .fin      (fin),
        .done     (done_flag),
        .err      (err_flag)
    );

    assign io_skip     = cmd.skip && done_flag;
    assign io_data_out = io_data_in | (cmd.read ? word : '0);

endmodule

// File: rtl/trc_checker.sv
module trc_checker (
    input logic clk,
    input logic rst,
    input logic io_strobe,
    input logic pulse_read,
    input logic pulse_start,
    input logic frm_valid,
    input logic frm_ready,
    input logic tape_absent,
    input logic done_flag,
    input logic err_flag
);

    assert_ready_gated_R4: assert property (@(posedge clk) disable iff (rst)
        frm_ready |-> (!done_flag && !tape_absent));

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && pulse_start) |=> (!done_flag && !err_flag));

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && pulse_read && !frm_ready && !tape_absent) |=> !done_flag);

    assert_err_brings_done_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> done_flag);

    assert_done_has_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> ($past(frm_valid && frm_ready) || $past(tape_absent)));

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (!done_flag && !err_flag && !frm_ready));

endmodule

bind tape_reader_ctrl trc_checker u_trc_checker (
    .clk         (clk),
    .rst         (rst),
    .io_strobe   (io_strobe),
    .pulse_read  (io_pulse[1]),
    .pulse_start (io_pulse[2]),
    .frm_valid   (frm_valid),
    .frm_ready   (frm_ready),
    .tape_absent (tape_absent),
    .done_flag   (done_flag),
    .err_flag    (err_flag)
);

// File: tb/tb_tape_reader_ctrl.sv
module tb_tape_reader_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_strobe = 1'b0;
    logic [5:0]  io_pulse = '0;
    logic [17:0] io_data_in = '0;
    logic [17:0] io_data_out;
    logic        io_skip;
    logic [1:0]  par_mode = 2'd0;
    logic        frm_valid = 1'b0;
    logic [7:0]  frm_data = '0;
    logic        frm_ready;
    logic        tape_absent = 1'b0;
    logic        done_flag;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    bit ended = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    tape_reader_ctrl dut (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .io_pulse(io_pulse),
        .io_data_in(io_data_in), .io_data_out(io_data_out), .io_skip(io_skip),
        .par_mode(par_mode), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_ready(frm_ready), .tape_absent(tape_absent),
        .done_flag(done_flag), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
        end
    endtask

    // Monitor: every read command is compared with the next queued word
    always @(negedge clk) begin
        #2;
        if (io_strobe && io_pulse[1]) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected read", io_data_out, '0);
            end else begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(io_data_out === e, t, io_data_out, e);
            end
        end
    end

    task automatic cmd(input logic [5:0] p, output logic skip);
        @(negedge clk);
        io_strobe = 1'b1;
        io_pulse  = p;
        #1 skip = io_skip;
        @(negedge clk);
        io_strobe = 1'b0;
        io_pulse  = '0;
    endtask

    task automatic expect_read(input logic [17:0] word, input string tag);
        logic s;
        exp_q.push_back(io_data_in | word);
        tag_q.push_back(tag);
        cmd(6'o02, s);
    endtask

    task automatic send(input logic [7:0] f);
        bit took = 0;
        @(negedge clk);
        frm_valid = 1'b1;
        frm_data  = f;
        for (int i = 0; i < 50 && !took; i++) begin
            #1;
            if (frm_ready) begin
                @(posedge clk);
                took = 1;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        frm_valid = 1'b0;
        if (!took) chk(1'b0, "R4 frame never taken", '0, 18'd1);
    endtask

    initial begin
        #1000000;
        if (!ended) begin
            ended = 1;
            chk(1'b0, "watchdog", '0, '0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk(done_flag === 1'b0, "R11 done after reset", 18'(done_flag), 0);
        chk(err_flag === 1'b0, "R11 err after reset", 18'(err_flag), 0);
        chk(frm_ready === 1'b0, "R11 ready after reset", 18'(frm_ready), 0);
        cmd(6'o01, s);
        chk(s === 1'b0, "R1 no skip when idle", 18'(s), 0);
        expect_read(18'o0, "R2 read after reset");
        io_data_in = 18'o525252;
        #1 chk(io_data_out === 18'o525252, "R2 pass-through", io_data_out, 18'o525252);
        io_data_in = '0;

        // R7 plain character read
        par_mode = 2'd0;
        cmd(6'o04, s);
        #1 chk(frm_ready === 1'b1, "R4 ready after start", 18'(frm_ready), 1);
        send(8'hC1);
        chk(done_flag === 1'b1, "R12 done after char frame", 18'(done_flag), 1);
        chk(frm_ready === 1'b0, "R4 ready low when done", 18'(frm_ready), 0);
        cmd(6'o01, s);
        chk(s === 1'b1, "R1 skip when done", 18'(s), 1);
        expect_read(18'h0C1, "R7 plain frame");
        #1 chk(done_flag === 1'b0, "R2 read clears done", 18'(done_flag), 0);
        cmd(6'o01, s);
        chk(s === 1'b0, "R1 no skip after read", 18'(s), 0);

        // R7 mode 3 also as received
        par_mode = 2'd3;
        cmd(6'o04, s);
        send(8'h3A);
        expect_read(18'h03A, "R7 mode 3 frame");

        // R8 even parity
        par_mode = 2'd1;
        cmd(6'o04, s);
        send(8'h43);
        expect_read(18'h0C3, "R8 odd count sets bit 7");
        cmd(6'o04, s);
        send(8'hC1);
        expect_read(18'h041, "R8 even count clears bit 7");

        // R9 forced
        par_mode = 2'd2;
        cmd(6'o04, s);
        send(8'h05);
        expect_read(18'h085, "R9 forced bit 7");

        // R5 / R6 binary packing
        cmd(6'o44, s);
        send(8'h12);
        chk(done_flag === 1'b0, "R5 unpunched frame ignored", 18'(done_flag), 0);
        send(8'h81);
        send(8'hBF);
        send(8'h40);
        chk(done_flag === 1'b0, "R6 not done before third", 18'(done_flag), 0);
        send(8'hC5);
        chk(done_flag === 1'b1, "R12 done on third punched frame", 18'(done_flag), 1);
        expect_read(18'o017705, "R6 R5 packed word");
        io_data_in = 18'o600000;
        expect_read(18'o017705, "R2 merged with bus");
        io_data_in = '0;

        // R3 restart mid binary read switches to character format
        cmd(6'o44, s);
        send(8'hFF);
        par_mode = 2'd0;
        cmd(6'o04, s);
        #1 chk(done_flag === 1'b0, "R3 restart keeps done low", 18'(done_flag), 0);
        send(8'h30);
        expect_read(18'h030, "R3 restart clears word");

        // R10 missing tape
        cmd(6'o04, s);
        @(negedge clk);
        tape_absent = 1'b1;
        #1 chk(frm_ready === 1'b0, "R4 ready low without tape", 18'(frm_ready), 0);
        @(negedge clk);
        chk(done_flag === 1'b1 && err_flag === 1'b1, "R10 flags set",
            {16'd0, done_flag, err_flag}, 18'd3);
        tape_absent = 1'b0;
        cmd(6'o01, s);
        chk(s === 1'b1, "R1 skip on error end", 18'(s), 1);
        expect_read(18'o0, "R10 word stays clear");
        #1 chk(err_flag === 1'b1, "R10 err survives read", 18'(err_flag), 1);
        cmd(6'o04, s);
        #1 chk(err_flag === 1'b0, "R3 start clears err", 18'(err_flag), 0);

        // R11 reset during binary read
        cmd(6'o44, s);
        send(8'hBF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 chk(frm_ready === 1'b0 && done_flag === 1'b0, "R11 reset mid read",
               {16'd0, frm_ready, done_flag}, 0);
        expect_read(18'o0, "R11 word cleared");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads seen", 18'(exp_q.size()), 0);
        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule